// File: doc/BRIEF.md
# Event-Reset Period Timer with Preload

An up-counting timer with a programmable period. It runs in one of three modes: free-running, a single shot that can be restarted, or a single shot that cannot. A group of external event inputs can reset the counter, and a mask register selects which of them count. The block puts out a one-clock period strobe and a one-clock reset/rollover strobe that other logic can use as conversion triggers. It also has a repetition flag that can be routed to an interrupt output.

The period and repetition values are written into preload registers. They move to the active registers only on an update event, which occurs when the repetition down-counter expires at a period match. A hold bit freezes that transfer, so that several values can be rewritten and then take effect together. While the timer is disabled and not held, a write goes straight through to the active register, so the timer can be set up before it is started. All control goes through a simple single-cycle write port.

Top module: `evt_period_timer`

## Requirements
- R1: After reset the counter is 0, the timer is disabled, the reset mask is 0, the hold bit and interrupt enable are 0, the repetition flag is 0, and all three strobes and the interrupt output are low.
- R2: A write takes effect at the clock edge where `wr_en` is high. Address 0 is control: bit 0 enable, bits 2:1 mode (0 free-running, 1 one-shot non-restartable, 2 one-shot restartable, 3 same as 0), bit 3 update hold, bit 4 interrupt enable. Address 1 is the period preload. Address 2 is the repetition preload (low 8 bits). Address 3 is the reset mask. Address 4 bit 0 set clears the flag. Address 5 bit 0 set is stop-and-reset.
- R3: In mode 0, enabling starts the count. The counter advances by one each clock and returns to 0 on the clock after it equals the active period P, so one cycle lasts P+1 clocks.
- R4: `per_pulse_o` is high for exactly the clocks in which the timer is counting and the counter equals the active period. `rst_pulse_o` is high for one clock, in the clock where the counter first shows 0 after a rollover or an accepted reset event.
- R5: Event input i causes a reset only while mask bit i is 1. In mode 0 an accepted event clears the counter at any count. In mode 2, if the event coincides with a period match, the reset wins and the shot goes on from 0, and the period strobe is still given.
- R6: In mode 1, enabling only arms the timer, and the counter holds. An accepted event starts a shot from 0. Events during the shot are ignored. At the period match the strobe fires and the counter stops at the period value. A later event starts a new shot from 0.
- R7: In mode 2, enabling only arms the timer. An accepted event starts a stopped counter from 0, or clears a running one to 0. At the period match the strobe fires and the counter stops.
- R8: Clearing the enable bit freezes the counter at its value and re-enabling in mode 0 resumes from it; stop-and-reset clears enable and forces the counter to 0.
- R9: With repetition value N, a repetition event occurs on every (N+1)-th period match. Each such event sets the flag one clock later. `rep_irq_o` follows the flag only while the interrupt enable is set. A clear write removes the flag, and a set in the same clock wins.
- R10: At a repetition event with hold clear, the preloaded period and repetition become active and `upd_pulse_o` is high in that clock. With hold set there is no transfer and no `upd_pulse_o`, and the pending values are applied at the first repetition event after hold is cleared.
- R11: A period or repetition write made while the timer is disabled and hold is clear also loads the active register, and for repetition it also loads the down-counter.
- R12: At a repetition event the down-counter reloads from the repetition value that is active after that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| evt_in | input | 4 | Reset event inputs, one per source |
| cnt_o | output | 16 | Current counter value |
| per_pulse_o | output | 1 | Period match strobe |
| rst_pulse_o | output | 1 | Reset/rollover strobe |
| upd_pulse_o | output | 1 | Preload transfer strobe |
| rep_flag_o | output | 1 | Repetition flag |
| rep_irq_o | output | 1 | Repetition interrupt |

## Verification
The bench sweeps the period from 0 to 4 and the repetition value from 0 to 3, and checks every clock against arithmetic expectations. An off-by-one in the wrap would stretch or shorten each cycle, and a miscounted down-counter would move the update strobe to the wrong period. Every pairing of mask bit and event input is tried, so a decode that ignores the mask resets on foreign events. The one-shot runs fire events in the middle of a shot and exactly on the period match: a non-restartable timer that honours them restarts early, and a restartable one that lets the period win stops instead of continuing from zero. The hold test rewrites the period under hold and checks that the old period stays in force until one full repetition event after release, which catches both an ignored hold and a pending update that is lost.

// File: rtl/ept_pkg.sv
package ept_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_ONE_NR = 2'd1,
        MODE_ONE_RT = 2'd2,
        MODE_RSV    = 2'd3
    } ept_mode_e;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PER  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_REP  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd5;

endpackage

// File: rtl/ept_regs.sv
module ept_regs
    import ept_pkg::*;
#(
    parameter int              CNT_W   = 16,
    parameter int              REP_W   = 8,
    parameter int              NUM_EVT = 4,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               rep_evt,
    output logic               en,
    output ept_mode_e          mode,
    output logic               hold,
    output logic [NUM_EVT-1:0] mask,
    output logic [CNT_W-1:0]   per_act,
    output logic [REP_W-1:0]   rep_act,
    output logic [REP_W-1:0]   rep_pre,
    output logic               flag,
    output logic               irq,
    output logic               sr_cmd,
    output logic               rep_ld
);

    typedef struct packed {
        logic               en;
        ept_mode_e          mode;
        logic               hold;
        logic               irq_en;
        logic [NUM_EVT-1:0] mask;
        logic [CNT_W-1:0]   per_pre;
        logic [CNT_W-1:0]   per_act;
        logic [REP_W-1:0]   rep_pre;
        logic [REP_W-1:0]   rep_act;
        logic               flag;
    } regs_t;

    regs_t s_d, s_q;
    logic  direct_ok;

    always_comb begin
        s_d       = s_q;
        direct_ok = !s_q.en && !s_q.hold;
        sr_cmd    = 1'b0;
        rep_ld    = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    s_d.en     = wr_data[0];
                    s_d.mode   = ept_mode_e'(wr_data[2:1]);
                    s_d.hold   = wr_data[3];
                    s_d.irq_en = wr_data[4];
                end
                ADR_PER: begin
                    s_d.per_pre = wr_data;
                    if (direct_ok) s_d.per_act = wr_data;
                end
                ADR_REP: begin
                    s_d.rep_pre = wr_data[REP_W-1:0];
                    if (direct_ok) begin
                        s_d.rep_act = wr_data[REP_W-1:0];
                        rep_ld      = 1'b1;
                    end
                end
                ADR_MASK: s_d.mask = wr_data[NUM_EVT-1:0];
                ADR_CLR:  if (wr_data[0]) s_d.flag = 1'b0;
                ADR_CMD: begin
                    if (wr_data[0]) begin
                        s_d.en = 1'b0;
                        sr_cmd = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (rep_evt) begin
            s_d.flag = 1'b1;
            if (!s_q.hold) begin
                s_d.per_act = s_q.per_pre;
                s_d.rep_act = s_q.rep_pre;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.mode    <= MODE_FREE;
            s_q.per_pre <= PER_RST;
            s_q.per_act <= PER_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign en      = s_q.en;
    assign mode    = s_q.mode;
    assign hold    = s_q.hold;
    assign mask    = s_q.mask;
    assign per_act = s_q.per_act;
    assign rep_act = s_q.rep_act;
    assign rep_pre = s_q.rep_pre;
    assign flag    = s_q.flag;
    assign irq     = s_q.flag && s_q.irq_en;

endmodule

// File: rtl/ept_core.sv
module ept_core
    import ept_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  ept_mode_e          mode,
    input  logic [NUM_EVT-1:0] mask,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [CNT_W-1:0]   per_act,
    input  logic               sr_cmd,
    output logic [CNT_W-1:0]   cnt,
    output logic               per_hit,
    output logic               rst_pulse,
    output logic               shot
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             shot;
        logic             rst_p;
    } core_t;

    core_t s_d, s_q;
    logic  evt_hit;
    logic  one_shot;
    logic  run;

    always_comb begin
        evt_hit  = |(evt_in & mask);
        one_shot = (mode == MODE_ONE_NR) || (mode == MODE_ONE_RT);
        run      = en && (one_shot ? s_q.shot : 1'b1);
        per_hit  = run && (s_q.cnt == per_act);

        s_d       = s_q;
        s_d.rst_p = 1'b0;
        if (sr_cmd) begin
            s_d.cnt  = '0;
            s_d.shot = 1'b0;
        end else if (!en) begin
            s_d.shot = 1'b0;
        end else begin
            case (mode)
                MODE_ONE_NR: begin
                    if (!s_q.shot) begin
                        if (evt_hit) begin
                            s_d.shot  = 1'b1;
                            s_d.cnt   = '0;
                            s_d.rst_p = 1'b1;
                        end
                    end else if (per_hit) begin
                        s_d.shot = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                MODE_ONE_RT: begin
                    if (evt_hit) begin
                        s_d.shot  = 1'b1;
                        s_d.cnt   = '0;
                        s_d.rst_p = 1'b1;
                    end else if (s_q.shot) begin
                        if (per_hit) s_d.shot = 1'b0;
                        else         s_d.cnt  = s_q.cnt + ONE;
                    end
                end
                default: begin
                    if (evt_hit || per_hit) begin
                        s_d.cnt   = '0;
                        s_d.rst_p = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt       = s_q.cnt;
    assign rst_pulse = s_q.rst_p;
    assign shot      = s_q.shot;

endmodule

// File: rtl/ept_rep.sv
module ept_rep #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_hit,
    input  logic             hold,
    input  logic [REP_W-1:0] rep_act,
    input  logic [REP_W-1:0] rep_pre,
    input  logic             ld,
    input  logic [REP_W-1:0] ld_val,
    output logic             rep_evt,
    output logic             upd
);

    localparam logic [REP_W-1:0] ONE = REP_W'(1);

    typedef struct packed {
        logic [REP_W-1:0] dn;
    } rep_t;

    rep_t s_d, s_q;

    always_comb begin
        rep_evt = per_hit && (s_q.dn == '0);
        upd     = rep_evt && !hold;
        s_d     = s_q;
        if (ld) begin
            s_d.dn = ld_val;
        end else if (per_hit) begin
            if (rep_evt) s_d.dn = hold ? rep_act : rep_pre;
            else         s_d.dn = s_q.dn - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/evt_period_timer.sv
module evt_period_timer
    import ept_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               REP_W   = 8,
    parameter int               NUM_EVT = 4,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               per_pulse_o,
    output logic               rst_pulse_o,
    output logic               upd_pulse_o,
    output logic               rep_flag_o,
    output logic               rep_irq_o
);

    logic               en_w;
    ept_mode_e          mode_w;
    logic               hold_w;
    logic [NUM_EVT-1:0] mask_w;
    logic [CNT_W-1:0]   per_act_w;
    logic [REP_W-1:0]   rep_act_w;
    logic [REP_W-1:0]   rep_pre_w;
    logic               sr_cmd_w;
    logic               rep_ld_w;
    logic               rep_evt_w;
    logic               per_hit_w;
    logic               shot_w;

    ept_regs #(
        .CNT_W(CNT_W), .REP_W(REP_W), .NUM_EVT(NUM_EVT), .PER_RST(PER_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rep_evt(rep_evt_w),
        .en(en_w), .mode(mode_w), .hold(hold_w), .mask(mask_w),
        .per_act(per_act_w), .rep_act(rep_act_w), .rep_pre(rep_pre_w),
        .flag(rep_flag_o), .irq(rep_irq_o),
        .sr_cmd(sr_cmd_w), .rep_ld(rep_ld_w)
    );

    ept_core #(
        .CNT_W(CNT_W), .NUM_EVT(NUM_EVT)
    ) core_i (
        .clk(clk), .rst_n(rst_n),
        .en(en_w), .mode(mode_w), .mask(mask_w), .evt_in(evt_in),
        .per_act(per_act_w), .sr_cmd(sr_cmd_w),
        .cnt(cnt_o), .per_hit(per_hit_w), .rst_pulse(rst_pulse_o),
        .shot(shot_w)
    );

    ept_rep #(
        .REP_W(REP_W)
    ) rep_i (
        .clk(clk), .rst_n(rst_n),
        .per_hit(per_hit_w), .hold(hold_w),
        .rep_act(rep_act_w), .rep_pre(rep_pre_w),
        .ld(rep_ld_w), .ld_val(wr_data[REP_W-1:0]),
        .rep_evt(rep_evt_w), .upd(upd_pulse_o)
    );

    assign per_pulse_o = per_hit_w;

endmodule

// File: rtl/ept_chk.sv
module ept_chk
    import ept_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_EVT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [1:0]         mode,
    input logic               shot,
    input logic               sr_cmd,
    input logic               per_hit,
    input logic               rst_pulse,
    input logic               hold,
    input logic               rep_evt,
    input logic               flag,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_EVT-1:0] evt_in,
    input logic [NUM_EVT-1:0] mask,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   per_act
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic evt_hit;
    assign evt_hit = |(evt_in & mask);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_FREE && per_hit && !sr_cmd) |=> (cnt == '0 && rst_pulse));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sr_cmd) |=> $stable(cnt));

    assert_srzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_cmd |=> (cnt == '0 && !en));

    assert_nr_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_ONE_NR && shot && !per_hit && !sr_cmd)
        |=> (cnt == $past(cnt) + ONE));

    assert_shot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && shot && per_hit && !sr_cmd &&
         (mode == MODE_ONE_NR || (mode == MODE_ONE_RT && !evt_hit)))
        |=> !per_hit);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !(wr_en && wr_addr == ADR_PER)) |=> $stable(per_act));

    assert_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rep_evt |=> flag);

endmodule

bind evt_period_timer ept_chk #(
    .CNT_W(CNT_W), .NUM_EVT(NUM_EVT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .mode(mode_w), .shot(shot_w),
    .sr_cmd(sr_cmd_w), .per_hit(per_hit_w), .rst_pulse(rst_pulse_o),
    .hold(hold_w), .rep_evt(rep_evt_w), .flag(rep_flag_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .evt_in(evt_in), .mask(mask_w),
    .cnt(cnt_o), .per_act(per_act_w)
);

// File: tb/evt_period_timer_tb_top.sv
module evt_period_timer_tb_top;
    import ept_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NEV        = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_addr = '0;
    logic [15:0]    wr_data = '0;
    logic [NEV-1:0] ev = '0;
    logic [15:0]    cnt_o;
    logic           per_pulse_o, rst_pulse_o, upd_pulse_o, rep_flag_o, rep_irq_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_period_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_in(ev), .cnt_o(cnt_o),
        .per_pulse_o(per_pulse_o), .rst_pulse_o(rst_pulse_o),
        .upd_pulse_o(upd_pulse_o), .rep_flag_o(rep_flag_o), .rep_irq_o(rep_irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse(input logic [NEV-1:0] bits);
        ev = bits;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic wait_per();
        for (int i = 0; i < 1000 && !per_pulse_o; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int c;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cnt", cnt_o, 0);
        check("R1 per strobe", per_pulse_o, 0);
        check("R1 rst strobe", rst_pulse_o, 0);
        check("R1 upd strobe", upd_pulse_o, 0);
        check("R1 flag", rep_flag_o, 0);
        check("R1 irq", rep_irq_o, 0);

        // R3 R4 R11: free-running sweep over period values loaded directly
        for (int p = 0; p < 5; p++) begin
            wr(ADR_CMD, 16'h1);
            wr(ADR_PER, 16'(p));
            wr(ADR_REP, 16'h0);
            wr(ADR_CTRL, 16'h1);
            for (int k = 0; k < 3*(p+1)+2; k++) begin
                check("R3 R11 count", cnt_o, k % (p+1));
                check("R4 period strobe", per_pulse_o, int'((k % (p+1)) == p));
                check("R4 rollover strobe", rst_pulse_o, int'(k > 0 && (k % (p+1)) == 0));
                @(negedge clk);
            end
        end

        // R9 R12: repetition sweep with period 2
        for (int n = 0; n < 4; n++) begin
            wr(ADR_CMD, 16'h1);
            wr(ADR_PER, 16'd2);
            wr(ADR_REP, 16'(n));
            wr(ADR_CLR, 16'h1);
            wr(ADR_CTRL, 16'h1);
            seen = 1'b0;
            for (int k = 0; k < 6*(n+1)+3; k++) begin
                bit ep, eu;
                ep = (k % 3) == 2;
                eu = ep && ((((k+1)/3) % (n+1)) == 0);
                check("R9 R12 update strobe", upd_pulse_o, int'(eu));
                check("R9 flag", rep_flag_o, int'(seen));
                check("R9 irq masked", rep_irq_o, 0);
                if (eu) seen = 1'b1;
                @(negedge clk);
            end
        end
        wr(ADR_CTRL, 16'h0011);
        check("R9 irq enabled", rep_irq_o, 1);
        wr(ADR_CMD, 16'h1);
        wr(ADR_CLR, 16'h1);
        check("R9 flag cleared", rep_flag_o, 0);
        check("R9 irq cleared", rep_irq_o, 0);

        // R10 hold and deferred update
        wr(ADR_CMD, 16'h1);
        wr(ADR_PER, 16'd2);
        wr(ADR_REP, 16'h0);
        wr(ADR_CTRL, 16'h1);
        wr(ADR_CTRL, 16'h9);
        wr(ADR_PER, 16'd4);
        wait_per();
        check("R10 held cnt", cnt_o, 2);
        check("R10 no update while held", upd_pulse_o, 0);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R10 old period kept", cnt_o, i);
            check("R10 old period strobe", per_pulse_o, int'(i == 2));
            if (i < 2) @(negedge clk);
        end
        wr(ADR_CTRL, 16'h1);
        wait_per();
        check("R10 pending applies at old period", cnt_o, 2);
        check("R10 update strobe after release", upd_pulse_o, 1);
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check("R10 new period count", cnt_o, i);
            check("R10 new period strobe", per_pulse_o, int'(i == 4));
            @(negedge clk);
        end

        // R5 mask sweep in free-running mode
        wr(ADR_CMD, 16'h1);
        wr(ADR_PER, 16'd9);
        wr(ADR_CTRL, 16'h1);
        for (int j = 0; j < NEV; j++) begin
            wr(ADR_MASK, 16'(1 << j));
            for (int i = 0; i < NEV; i++) begin
                c = int'(cnt_o);
                pulse(NEV'(1 << i));
                check("R5 masked reset count", cnt_o, (i == j || c == 9) ? 0 : c + 1);
                check("R5 masked reset strobe", rst_pulse_o, int'(i == j || c == 9));
            end
        end

        // R6 one-shot non-restartable (R2 mode field 1)
        wr(ADR_CMD, 16'h1);
        wr(ADR_PER, 16'd4);
        wr(ADR_MASK, 16'h1);
        wr(ADR_CTRL, 16'h3);
        for (int i = 0; i < 3; i++) begin
            check("R2 R6 armed holds", cnt_o, 0);
            check("R6 armed no strobe", per_pulse_o, 0);
            @(negedge clk);
        end
        pulse(4'b0001);
        check("R6 start", cnt_o, 0);
        check("R6 start strobe", rst_pulse_o, 1);
        @(negedge clk);
        @(negedge clk);
        check("R6 counting", cnt_o, 2);
        pulse(4'b0001);
        check("R6 event ignored", cnt_o, 3);
        check("R6 no reset strobe", rst_pulse_o, 0);
        @(negedge clk);
        check("R6 period reached", cnt_o, 4);
        check("R6 period strobe", per_pulse_o, 1);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R6 stopped value", cnt_o, 4);
            check("R6 stopped no strobe", per_pulse_o, 0);
        end
        pulse(4'b0001);
        check("R6 new shot", cnt_o, 0);
        @(negedge clk);
        check("R6 new shot counts", cnt_o, 1);

        // R7 one-shot restartable, and R5 reset beating period match
        wr(ADR_CMD, 16'h1);
        wr(ADR_CTRL, 16'h5);
        @(negedge clk);
        check("R7 armed holds", cnt_o, 0);
        pulse(4'b0001);
        check("R7 start", cnt_o, 0);
        @(negedge clk);
        @(negedge clk);
        check("R7 counting", cnt_o, 2);
        pulse(4'b0001);
        check("R7 retrigger clears", cnt_o, 0);
        check("R7 retrigger strobe", rst_pulse_o, 1);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R7 at period", cnt_o, 4);
        check("R5 period strobe with reset", per_pulse_o, 1);
        pulse(4'b0001);
        check("R5 reset wins", cnt_o, 0);
        @(negedge clk);
        check("R5 shot continues", cnt_o, 1);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R7 period strobe", per_pulse_o, 1);
        @(negedge clk);
        check("R7 stopped", cnt_o, 4);
        check("R7 stopped no strobe", per_pulse_o, 0);

        // R8 stop and stop-and-reset
        wr(ADR_CMD, 16'h1);
        wr(ADR_PER, 16'd100);
        wr(ADR_CTRL, 16'h1);
        repeat (5) @(negedge clk);
        check("R8 running", cnt_o, 5);
        wr(ADR_CTRL, 16'h0);
        check("R8 stop value", cnt_o, 6);
        repeat (3) @(negedge clk);
        check("R8 frozen", cnt_o, 6);
        wr(ADR_CTRL, 16'h1);
        check("R8 resume start", cnt_o, 6);
        @(negedge clk);
        check("R8 resumed", cnt_o, 7);
        wr(ADR_CMD, 16'h1);
        check("R8 stop-and-reset", cnt_o, 0);
        @(negedge clk);
        check("R8 stays zero", cnt_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule